// File: doc/BRIEF.md
# Keyed Watchdog Timer with Boot Flash Swap

This block is a memory-mapped watchdog timer. A 32-bit down-counter runs from a periodic tick. The tick comes either from a prescaler that turns the system clock into 1 MHz, or straight from the system clock. Software keeps the system alive by writing one fixed key to a restart register, which copies the programmed reload value into the counter. A write of any other value to that register does nothing.

When the counter expires, the block raises a one-cycle timeout strobe and reloads the counter, which then keeps counting. Depending on the control register, the expiry also raises:

- a reset request, tagged with a reset kind;
- a sticky interrupt;
- a one-cycle trigger for an external pulse generator;
- a latched boot-from-alternate-flash flag.

While that flag is set, the block swaps the two flash chip-select lines that pass through it. Writing the clear register restores the normal mapping.

The register bus is a single-cycle write port with combinational read data. Word offsets are taken from address bits 4:2. Address bits 1:0 must be zero for a write to take effect.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the count and reload registers both read INIT_COUNT, and the control and status registers read 0. All event outputs are low, and the chip-select outputs equal the inputs.
- R2: The register map is: 0x00 count (read only; writes are ignored), 0x04 reload (read/write), 0x08 restart (reads 0), 0x0C control (8 bits; upper write bits dropped), 0x10 status, 0x14 clear (reads 0).
- R3: A write to offset 0x08 loads the reload value into the counter only when the full 32-bit data equals 0x00004755. Any other data leaves the counter unchanged.
- R4: While control bit 0 (enable) is 0, the counter holds its value. A keyed restart still loads it.
- R5: With enable set, the counter decrements by one per tick. A tick that finds the count at 0 raises timeoutPulse for one cycle and reloads the counter, so timeouts repeat every reload+1 ticks. With a tick on every clock, the first timeout appears reload+1 cycles after the enabling write.
- R6: With control bit 4 set, a tick occurs every CLK_HZ/TICK_HZ system clocks. With bit 4 clear, a tick occurs on every system clock.
- R7: resetReq pulses together with timeoutPulse only if control bit 1 was set at expiry. resetKind always shows control bits 6:5, where 0 means SoC reset, 1 means full-chip reset and 2 means CPU-only reset.
- R8: An expiry with control bit 2 set raises irq, and irq stays high until cleared. An expiry with control bit 3 set raises extTrigger for exactly one cycle, together with timeoutPulse.
- R9: Status bit 0 is set by any expiry. Status bit 1 is set by an expiry with control bit 7 set. While status bit 1 is set, csOut[0]=csIn[1] and csOut[1]=csIn[0]. Both status bits are sticky.
- R10: A write to offset 0x14 with data bit 0 set clears both status bits and irq, which restores the normal chip-select mapping. The same write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| timeoutPulse | output | 1 | One-cycle strobe on each expiry |
| resetReq | output | 1 | One-cycle reset request on expiry |
| resetKind | output | 2 | Reset scope selected by control bits 6:5 |
| irq | output | 1 | Sticky timeout interrupt |
| extTrigger | output | 1 | One-cycle trigger for the external pulse |
| csIn | input | 2 | Flash chip selects from the controller |
| csOut | output | 2 | Flash chip selects to the devices, swapped while boot-alternate is latched |

## Verification
On every cycle, the assertions check how the counter moves:

- it holds while disabled;
- it steps down by exactly one on a tick;
- it lands on the reload value after a restart or an expiry.

They also check that irq and the swap flag are sticky, that a clear empties the sticky state, and that resetReq and extTrigger never occur without a timeout strobe.

Only the bench scenarios can show the things that depend on absolute timing or on software-visible contents:

- the exact reload+1 period for several reload values;
- the prescaled period;
- that wrong keys and a clear word without bit 0 are rejected;
- the register readback;
- the actual chip-select routing.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  // word index = busAddr[4:2]
  localparam logic [2:0] REG_COUNT   = 3'd0;
  localparam logic [2:0] REG_RELOAD  = 3'd1;
  localparam logic [2:0] REG_RESTART = 3'd2;
  localparam logic [2:0] REG_CTRL    = 3'd3;
  localparam logic [2:0] REG_STATUS  = 3'd4;
  localparam logic [2:0] REG_CLEAR   = 3'd5;

  localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_4755;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_RST  = 1;
  localparam int CB_IRQ  = 2;
  localparam int CB_EXT  = 3;
  localparam int CB_DIV  = 4;
  localparam int CB_MODE = 5;
  localparam int CB_BOOT = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic writeReload;
    logic restart;
    logic run;
    logic divTick;
  } dpCmd_t;

endpackage

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int          DIV        = 50,
  parameter logic [31:0] INIT_COUNT = 32'd30_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  countQ,
  output logic [CNT_W-1:0]  reloadQ,
  output logic              expire
);

  logic slowTick;
  logic tick;

  generate
    if (DIV > 1) begin : g_prescale
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] preQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              preQ <= '0;
        else if (preQ == LAST)  preQ <= '0;
        else                    preQ <= preQ + 1'b1;
      end
      assign slowTick = (preQ == LAST);
    end else begin : g_noPrescale
      assign slowTick = 1'b1;
    end
  endgenerate

  assign tick   = cmd.divTick ? slowTick : 1'b1;
  assign expire = cmd.run & tick & (countQ == '0) & ~cmd.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= CNT_W'(INIT_COUNT);
    end else if (cmd.writeReload) begin
      reloadQ <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= CNT_W'(INIT_COUNT);
    end else if (cmd.restart) begin
      countQ <= reloadQ;
    end else if (cmd.run && tick) begin
      if (countQ == '0) countQ <= reloadQ;
      else              countQ <= countQ - 1'b1;
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.restart) |=> $stable(countQ));

  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.run && tick && countQ != '0 && !cmd.restart) |=> (countQ == $past(countQ) - 1'b1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (countQ == $past(reloadQ)));

  a_r3_restart_load: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (countQ == $past(reloadQ)));

endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countQ,
  input  logic [CNT_W-1:0]  reloadQ,
  input  logic              expire,
  output dpCmd_t            cmd,
  output logic              timeoutPulse,
  output logic              resetReq,
  output logic [1:0]        resetKind,
  output logic              irq,
  output logic              extTrigger,
  output logic              bootSwap
);

  logic [2:0] regIdx;
  logic       aligned;
  logic       wrHit;
  logic       clearHit;
  logic [7:0] ctrlQ;
  logic       timedOutQ;

  assign regIdx   = busAddr[4:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign wrHit    = busWe & aligned;
  assign clearHit = wrHit & (regIdx == REG_CLEAR) & busWdata[0];

  always_comb begin
    cmd.writeReload = wrHit & (regIdx == REG_RELOAD);
    cmd.restart     = wrHit & (regIdx == REG_RESTART) & (busWdata == RESTART_KEY);
    cmd.run         = ctrlQ[CB_EN];
    cmd.divTick     = ctrlQ[CB_DIV];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              ctrlQ <= '0;
    else if (wrHit && regIdx == REG_CTRL)   ctrlQ <= busWdata[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutPulse <= 1'b0;
      resetReq     <= 1'b0;
      extTrigger   <= 1'b0;
    end else begin
      timeoutPulse <= expire;
      resetReq     <= expire & ctrlQ[CB_RST];
      extTrigger   <= expire & ctrlQ[CB_EXT];
    end
  end

  // sticky state: a new expiry wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timedOutQ <= 1'b0;
      bootSwap  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (clearHit) begin
        timedOutQ <= 1'b0;
        bootSwap  <= 1'b0;
        irq       <= 1'b0;
      end
      if (expire) begin
        timedOutQ <= 1'b1;
        if (ctrlQ[CB_BOOT]) bootSwap <= 1'b1;
        if (ctrlQ[CB_IRQ])  irq      <= 1'b1;
      end
    end
  end

  assign resetKind = ctrlQ[CB_MODE+1:CB_MODE];

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      case (regIdx)
        REG_COUNT:  busRdata = DATA_W'(countQ);
        REG_RELOAD: busRdata = DATA_W'(reloadQ);
        REG_CTRL:   busRdata = DATA_W'(ctrlQ);
        REG_STATUS: busRdata = DATA_W'({bootSwap, timedOutQ});
        default:    busRdata = '0;
      endcase
    end
  end

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clearHit) |=> irq);

  a_r9_swap_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (bootSwap && !clearHit) |=> bootSwap);

  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (clearHit && !expire) |=> (!bootSwap && !irq && !timedOutQ));

  a_r7_reset_with_timeout: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> timeoutPulse);

  a_r8_ext_with_timeout: assert property (@(posedge clk) disable iff (!rstN)
    extTrigger |-> timeoutPulse);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          TICK_HZ    = 1_000_000,
  parameter int          CNT_W      = 32,
  parameter logic [31:0] INIT_COUNT = 32'd30_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        timeoutPulse,
  output logic        resetReq,
  output logic [1:0]  resetKind,
  output logic        irq,
  output logic        extTrigger,
  input  logic [1:0]  csIn,
  output logic [1:0]  csOut
);

  localparam int DIV = CLK_HZ / TICK_HZ;

  dpCmd_t           cmd;
  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;
  logic             expire;
  logic             bootSwap;

  kwd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .countQ(countQ), .reloadQ(reloadQ), .expire(expire), .cmd(cmd),
    .timeoutPulse(timeoutPulse), .resetReq(resetReq), .resetKind(resetKind),
    .irq(irq), .extTrigger(extTrigger), .bootSwap(bootSwap)
  );

  kwd_datapath #(.CNT_W(CNT_W), .DIV(DIV), .INIT_COUNT(INIT_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wdata(busWdata),
    .countQ(countQ), .reloadQ(reloadQ), .expire(expire)
  );

  assign csOut = bootSwap ? {csIn[0], csIn[1]} : csIn;

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

  localparam int          DIV  = 5;
  localparam logic [31:0] INIT = 32'd300;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        timeoutPulse, resetReq, irq, extTrigger;
  logic [1:0]  resetKind;
  logic [1:0]  csIn = 2'b01;
  logic [1:0]  csOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  keyed_watchdog #(.CLK_HZ(DIV * 1_000_000), .TICK_HZ(1_000_000), .INIT_COUNT(INIT)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .timeoutPulse(timeoutPulse), .resetReq(resetReq),
    .resetKind(resetKind), .irq(irq), .extTrigger(extTrigger), .csIn(csIn), .csOut(csOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic nextPulse(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!timeoutPulse && k < 5000);
  endtask

  task automatic runAll();
    logic [31:0] d;
    int k;
    int rs[5] = '{0, 1, 2, 5, 9};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(5'h00, d); chk("R1 count", d, INIT);
    rd(5'h04, d); chk("R1 reload", d, INIT);
    rd(5'h0C, d); chk("R1 ctrl", d, 0);
    rd(5'h10, d); chk("R1 status", d, 0);
    chk("R1 outputs", {28'd0, timeoutPulse, resetReq, irq, extTrigger}, 0);
    chk("R1 cs straight", {30'd0, csOut}, 32'h1);
    // R2 map
    wr(5'h00, 32'd77); rd(5'h00, d); chk("R2 count read-only", d, INIT);
    wr(5'h0C, 32'h1E0); rd(5'h0C, d); chk("R2 ctrl 8 bits", d, 32'hE0);
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'd10); rd(5'h04, d); chk("R2 reload rw", d, 10);
    rd(5'h08, d); chk("R2 restart reads 0", d, 0);
    // R3 key
    wr(5'h08, 32'h0000_4756); rd(5'h00, d); chk("R3 wrong key", d, INIT);
    wr(5'h08, 32'h0001_4755); rd(5'h00, d); chk("R3 upper bits", d, INIT);
    wr(5'h08, 32'h0000_4755); rd(5'h00, d); chk("R3 key loads", d, 10);
    // R4 hold
    repeat (20) @(negedge clk);
    rd(5'h00, d); chk("R4 hold disabled", d, 10);
    // R5 sweep of reload values, tick every clock
    foreach (rs[i]) begin
      wr(5'h04, rs[i]);
      wr(5'h08, 32'h4755);
      wr(5'h0C, 32'h01);
      if (rs[i] == 5) begin
        repeat (2) @(negedge clk);
        rd(5'h00, d); chk("R5 decrement", d, 2);
        nextPulse(k); chk("R5 first timeout", k, 3);
      end else begin
        nextPulse(k); chk("R5 first timeout", k, rs[i] + 1);
      end
      chk("R7 no reset without bit1", resetReq, 0);
      chk("R8 no irq without bit2", irq, 0);
      nextPulse(k); chk("R5 period", k, rs[i] + 1);
      wr(5'h0C, 32'h0);
    end
    // R6 prescaled tick
    wr(5'h04, 32'd3); wr(5'h08, 32'h4755);
    wr(5'h0C, 32'h11);
    nextPulse(k);
    nextPulse(k); chk("R6 prescaled period", k, 4 * DIV);
    wr(5'h0C, 32'h0);
    // R7 reset request and kind
    wr(5'h08, 32'h4755);
    wr(5'h0C, 32'h43);
    chk("R7 kind cpu", resetKind, 2);
    nextPulse(k);
    chk("R7 reset with bit1", resetReq, 1);
    chk("R8 ext off", extTrigger, 0);
    wr(5'h0C, 32'h21);
    chk("R7 kind full chip", resetKind, 1);
    nextPulse(k);
    chk("R7 no reset bit1 clear", resetReq, 0);
    wr(5'h0C, 32'h0);
    // R8 irq and ext trigger
    wr(5'h08, 32'h4755);
    wr(5'h0C, 32'h0D);
    nextPulse(k);
    chk("R8 ext with timeout", extTrigger, 1);
    chk("R8 irq set", irq, 1);
    @(negedge clk);
    chk("R8 ext one cycle", extTrigger, 0);
    wr(5'h0C, 32'h0);
    repeat (10) @(negedge clk);
    chk("R8 irq sticky", irq, 1);
    // R9 status and swap
    rd(5'h10, d); chk("R9 status timeout only", d, 1);
    chk("R9 no swap yet", csOut, 2'b01);
    wr(5'h08, 32'h4755);
    wr(5'h0C, 32'h81);
    nextPulse(k);
    wr(5'h0C, 32'h0);
    rd(5'h10, d); chk("R9 status boot", d, 3);
    chk("R9 swapped 01", csOut, 2'b10);
    csIn = 2'b10; #1;
    chk("R9 swapped 10", csOut, 2'b01);
    csIn = 2'b01;
    // R10 clear
    wr(5'h14, 32'h2); rd(5'h10, d); chk("R10 clear bit0 zero ignored", d, 3);
    chk("R10 irq kept", irq, 1);
    wr(5'h14, 32'h1); rd(5'h10, d); chk("R10 status cleared", d, 0);
    chk("R10 irq cleared", irq, 0);
    chk("R10 cs restored", csOut, 2'b01);
    wr(5'h14, 32'h1); rd(5'h10, d); chk("R10 second clear", d, 0);
    chk("R10 cs still normal", csOut, 2'b01);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule